// File: doc/BRIEF.md
# Flash Write Protection Gate

This block sits between the command requester of a serial flash controller and its dispatch stage. It decides for each command whether it may go on to the flash. Two independent checks run side by side, and their verdicts are ORed:

- **Range check.** A small set of page ranges, each with a base, an inclusive limit and an enable bit, blocks write-type commands whose address falls inside an enabled range.
- **Global check.** A global write-protect flag blocks every write-type command.

A per-opcode table, written by boot software, says which opcode slots count as writes. Read-type commands always pass.

A blocked command is never forwarded. It still completes toward the requester one cycle after the request, looking like a normal completion. It also sets a sticky status bit that software clears by writing 1.

A lock bit, once set, freezes the ranges, the opcode table and the global flag until the next reset. The global flag resets to protecting. It can only be relaxed while an external override request is held high.

Top module: `flash_wp_gate`

## Requirements
- R1: A command whose opcode slot is marked as read (opcode table bit 0) is forwarded, even inside an enabled range and with the global flag set.
- R2: A write-type command is blocked when its page (address bits 24:12) satisfies base <= page <= limit for an enabled range. A range register word holds base in bits 12:0, limit in bits 28:16 and enable in bit 31. Pages base-1 and limit+1 pass.
- R3: A range whose enable bit is 0 blocks nothing.
- R4: The global write-protect flag resets to 1. While it is 1, every write-type command is blocked, whatever its page.
- R5: Writing 0 to the global flag (control register bit 1) clears it only if ovr_req is high in that cycle. Otherwise the write is ignored. Writing 1 sets it.
- R6: Once the lock (control register bit 0) is set, it stays set until reset. While it is set, writes to the range registers, the opcode table and the global flag are ignored.
- R7: A blocked command produces no fwd_valid and raises cmd_done for one cycle, one cycle after the request.
- R8: An allowed command raises fwd_valid, with its opcode and address, one cycle after the request. cmd_done follows one cycle after flash_done.
- R9: blk_sts is set by a blocked command and holds until a write of 1 to status bit 0. If a block and a clear happen in the same cycle, the block wins.
- R10: A request that arrives while a forwarded command is still outstanding is ignored. It causes no forward, no completion and no status change.
- R11: After reset, fwd_valid, cmd_done, blk_sts and wp_locked are 0 and gwp_active is 1.

Register addresses: ranges at 0 to NUM_RANGES-1, opcode table at NUM_RANGES, control at NUM_RANGES+1, status at NUM_RANGES+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| ovr_req | input | 1 | Override request permitting the global flag to be cleared |
| req_valid | input | 1 | Command request strobe |
| req_op | input | 3 | Opcode slot index of the request |
| req_addr | input | 25 | Byte address of the request |
| flash_done | input | 1 | Completion from the flash side for a forwarded command |
| fwd_valid | output | 1 | Command forwarded to the flash side |
| fwd_op | output | 3 | Forwarded opcode slot |
| fwd_addr | output | 25 | Forwarded address |
| cmd_done | output | 1 | Completion pulse to the requester |
| blk_sts | output | 1 | Sticky blocked-access status |
| wp_locked | output | 1 | Lock state |
| gwp_active | output | 1 | Global write-protect flag |

## Verification
The bench probes both edges of a range, the page just outside each edge, a one-page range at the top of the address space, and a disabled range with valid bounds. An off-by-one compare would either block a neighbouring page or let a boundary page through.

It also tries the following:
- A global-flag clear without the override. A design that skipped that guard would let writes through.
- A clear of the status bit in the same cycle as a block. A design with the wrong priority would lose the event.
- Configuration changes after lock. A design with a leaky lock would unprotect a range.
- A request during an outstanding forward. A design that accepted it would forward twice or complete early.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int PAGE_W     = 13;
  localparam int PAGE_SHIFT = 12;
  localparam int CFG_DW     = 32;
  localparam int LIM_LSB    = 16;
  localparam int EN_BIT     = 31;

  typedef struct packed {
    logic              en;
    logic [PAGE_W-1:0] limit;
    logic [PAGE_W-1:0] base;
  } wp_range_t;

  function automatic wp_range_t word_to_range(input logic [CFG_DW-1:0] w);
    wp_range_t r;
    r.en    = w[EN_BIT];
    r.limit = w[LIM_LSB +: PAGE_W];
    r.base  = w[0 +: PAGE_W];
    return r;
  endfunction
endpackage

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs
  import wp_pkg::*;
#(
  parameter int NUM_RANGES = 4,
  parameter int NUM_OPS    = 8,
  parameter int CFG_AW     = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  logic [CFG_AW-1:0]                cfg_addr,
  input  logic [CFG_DW-1:0]                cfg_wdata,
  input  logic                             ovr_req,
  input  logic                             blk_set,
  output wp_range_t [NUM_RANGES-1:0]       ranges_q,
  output logic [NUM_OPS-1:0]               optab_q,
  output logic                             lock_q,
  output logic                             gwp_q,
  output logic                             blk_sts_q
);
  localparam logic [CFG_AW-1:0] A_OPTAB = CFG_AW'(NUM_RANGES);
  localparam logic [CFG_AW-1:0] A_CTRL  = CFG_AW'(NUM_RANGES + 1);
  localparam logic [CFG_AW-1:0] A_STS   = CFG_AW'(NUM_RANGES + 2);

  logic open_wr;
  logic ctrl_wr;
  logic sts_clr;
  logic unused_cfg_par;

  assign open_wr        = cfg_we && !lock_q;
  assign ctrl_wr        = cfg_we && (cfg_addr == A_CTRL);
  assign sts_clr        = cfg_we && (cfg_addr == A_STS) && cfg_wdata[0];
  assign unused_cfg_par = ^cfg_wdata;

  // Range registers, one per generated slot.
  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_rng
    always_ff @(posedge clk) begin
      if (rst) begin
        ranges_q[i] <= '0;
      end else if (open_wr && (cfg_addr == CFG_AW'(i))) begin
        ranges_q[i] <= word_to_range(cfg_wdata);
      end
    end
  end

  // Opcode-type table: bit set means the slot is a write.
  always_ff @(posedge clk) begin
    if (rst) begin
      optab_q <= '0;
    end else if (open_wr && (cfg_addr == A_OPTAB)) begin
      optab_q <= cfg_wdata[NUM_OPS-1:0];
    end
  end

  // Lock (set only) and global protect flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      gwp_q  <= 1'b1;
    end else begin
      if (ctrl_wr && cfg_wdata[0]) begin
        lock_q <= 1'b1;
      end
      if (ctrl_wr && !lock_q) begin
        if (cfg_wdata[1]) begin
          gwp_q <= 1'b1;
        end else if (ovr_req) begin
          gwp_q <= 1'b0;
        end
      end
    end
  end

  // Sticky status, write-1-to-clear, set has priority.
  always_ff @(posedge clk) begin
    if (rst) begin
      blk_sts_q <= 1'b0;
    end else if (blk_set) begin
      blk_sts_q <= 1'b1;
    end else if (sts_clr) begin
      blk_sts_q <= 1'b0;
    end
  end

  a_r6_lock_holds: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  a_r6_ranges_frozen: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> ($stable(ranges_q) && $stable(optab_q) && $stable(gwp_q)));
  a_r5_relax_needs_ovr: assert property (@(posedge clk) disable iff (rst)
    $fell(gwp_q) |-> $past(ovr_req));
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (blk_sts_q && !sts_clr) |=> blk_sts_q);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    blk_set |=> blk_sts_q);
endmodule

// File: rtl/wp_range_check.sv
module wp_range_check
  import wp_pkg::*;
#(
  parameter int NUM_RANGES = 4
) (
  input  wp_range_t [NUM_RANGES-1:0] ranges,
  input  logic [PAGE_W-1:0]          page,
  output logic                       hit
);
  logic [NUM_RANGES-1:0] hit_vec;

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_cmp
    assign hit_vec[i] = ranges[i].en
                     && (page >= ranges[i].base)
                     && (page <= ranges[i].limit);
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/wp_cmd_gate.sv
module wp_cmd_gate #(
  parameter int ADDR_W   = 25,
  parameter int OP_IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [OP_IDX_W-1:0] req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                is_write,
  input  logic                gwp,
  input  logic                range_hit,
  input  logic                flash_done,
  output logic                fwd_valid,
  output logic [OP_IDX_W-1:0] fwd_op,
  output logic [ADDR_W-1:0]   fwd_addr,
  output logic                cmd_done,
  output logic                blk_set,
  output logic                busy
);
  logic accept;
  logic blocked;
  logic pass;

  assign accept  = req_valid && !busy;
  assign blocked = is_write && (gwp || range_hit);
  assign pass    = accept && !blocked;
  assign blk_set = accept && blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_op    <= '0;
      fwd_addr  <= '0;
      cmd_done  <= 1'b0;
      busy      <= 1'b0;
    end else begin
      fwd_valid <= pass;
      if (pass) begin
        fwd_op   <= req_op;
        fwd_addr <= req_addr;
      end
      cmd_done <= blk_set || (busy && flash_done);
      if (pass) begin
        busy <= 1'b1;
      end else if (flash_done) begin
        busy <= 1'b0;
      end
    end
  end

  a_r7_blocked_done: assert property (@(posedge clk) disable iff (rst)
    blk_set |=> (cmd_done && !fwd_valid));
  a_r8_forward: assert property (@(posedge clk) disable iff (rst)
    (accept && !blk_set) |=> (fwd_valid && busy));
  a_r8_done_follows: assert property (@(posedge clk) disable iff (rst)
    (busy && flash_done) |=> (cmd_done && !busy));
  a_r10_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    (busy && !flash_done) |=> !fwd_valid);
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
  import wp_pkg::*;
#(
  parameter int NUM_RANGES = 4,
  parameter int NUM_OPS    = 8,
  localparam int OP_IDX_W  = $clog2(NUM_OPS),
  localparam int ADDR_W    = PAGE_W + PAGE_SHIFT,
  localparam int CFG_AW    = $clog2(NUM_RANGES + 3)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [CFG_DW-1:0]   cfg_wdata,
  input  logic                ovr_req,
  input  logic                req_valid,
  input  logic [OP_IDX_W-1:0] req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                flash_done,
  output logic                fwd_valid,
  output logic [OP_IDX_W-1:0] fwd_op,
  output logic [ADDR_W-1:0]   fwd_addr,
  output logic                cmd_done,
  output logic                blk_sts,
  output logic                wp_locked,
  output logic                gwp_active
);
  wp_range_t [NUM_RANGES-1:0] ranges_q;
  logic [NUM_OPS-1:0]         optab_q;
  logic                       range_hit;
  logic                       blk_set;
  logic                       busy;
  logic                       is_write;

  assign is_write = optab_q[req_op];

  wp_cfg_regs #(
    .NUM_RANGES(NUM_RANGES),
    .NUM_OPS   (NUM_OPS),
    .CFG_AW    (CFG_AW)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .ovr_req   (ovr_req),
    .blk_set   (blk_set),
    .ranges_q  (ranges_q),
    .optab_q   (optab_q),
    .lock_q    (wp_locked),
    .gwp_q     (gwp_active),
    .blk_sts_q (blk_sts)
  );

  wp_range_check #(
    .NUM_RANGES(NUM_RANGES)
  ) u_rng (
    .ranges (ranges_q),
    .page   (req_addr[ADDR_W-1:PAGE_SHIFT]),
    .hit    (range_hit)
  );

  wp_cmd_gate #(
    .ADDR_W  (ADDR_W),
    .OP_IDX_W(OP_IDX_W)
  ) u_gate (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .is_write   (is_write),
    .gwp        (gwp_active),
    .range_hit  (range_hit),
    .flash_done (flash_done),
    .fwd_valid  (fwd_valid),
    .fwd_op     (fwd_op),
    .fwd_addr   (fwd_addr),
    .cmd_done   (cmd_done),
    .blk_set    (blk_set),
    .busy       (busy)
  );

  a_r1_reads_pass: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && !optab_q[req_op]) |=> fwd_valid);
  a_r4_global_blocks: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && optab_q[req_op] && gwp_active) |=> !fwd_valid);
endmodule

// File: tb/flash_wp_gate_test.sv
module flash_wp_gate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        ovr_req = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [24:0] req_addr = '0;
  logic        flash_done = 1'b0;
  logic        fwd_valid;
  logic [2:0]  fwd_op;
  logic [24:0] fwd_addr;
  logic        cmd_done;
  logic        blk_sts;
  logic        wp_locked;
  logic        gwp_active;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  localparam logic [2:0] A_OPTAB = 3'd4;
  localparam logic [2:0] A_CTRL  = 3'd5;
  localparam logic [2:0] A_STS   = 3'd6;

  // {op[2:0], page[12:0], expect_blocked}
  localparam logic [16:0] VEC [0:8] = '{
    {3'd0, 13'h0010, 1'b0},   // R1 read inside range
    {3'd1, 13'h0010, 1'b1},   // R2 base page
    {3'd1, 13'h001F, 1'b1},   // R2 limit page
    {3'd1, 13'h000F, 1'b0},   // R2 base-1
    {3'd2, 13'h0020, 1'b0},   // R2 limit+1
    {3'd2, 13'h0015, 1'b1},   // R2 interior
    {3'd1, 13'h0100, 1'b0},   // R3 disabled range
    {3'd1, 13'h1FFF, 1'b1},   // R2 top single-page range
    {3'd3, 13'h1FFF, 1'b0}    // R1 read-type slot
  };

  flash_wp_gate uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ovr_req(ovr_req), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .flash_done(flash_done),
    .fwd_valid(fwd_valid), .fwd_op(fwd_op), .fwd_addr(fwd_addr),
    .cmd_done(cmd_done), .blk_sts(blk_sts), .wp_locked(wp_locked),
    .gwp_active(gwp_active)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [12:0] page,
                       input bit exp_blk, input string tag);
    logic [24:0] a;
    a = {page, 12'hABC};
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_blk) begin
      chk(cmd_done === 1'b1 && fwd_valid === 1'b0, tag,
          {30'd0, fwd_valid, cmd_done}, 32'h1);
      chk(blk_sts === 1'b1, tag, {31'd0, blk_sts}, 32'h1);
    end else begin
      chk(fwd_valid === 1'b1 && cmd_done === 1'b0 && fwd_addr === a
          && fwd_op === op, tag, {4'd0, fwd_op, fwd_addr}, {4'd0, op, a});
      flash_done = 1'b1;
      @(negedge clk);
      flash_done = 1'b0;
      chk(cmd_done === 1'b1, tag, {31'd0, cmd_done}, 32'h1);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk(fwd_valid === 0 && cmd_done === 0 && blk_sts === 0 && wp_locked === 0
        && gwp_active === 1, "R11 reset state",
        {27'd0, fwd_valid, cmd_done, blk_sts, wp_locked, gwp_active}, 32'h1);

    cfg_write(A_OPTAB, 32'h0000_0006);
    cfg_write(3'd0, (32'h1 << 31) | (32'h001F << 16) | 32'h0010);
    cfg_write(3'd1, (32'h0100 << 16) | 32'h0100);
    cfg_write(3'd2, (32'h1 << 31) | (32'h1FFF << 16) | 32'h1FFF);

    // R4 global flag blocks any write page; reads still pass (R1)
    issue(3'd1, 13'h0500, 1'b1, "R4 global blocks write");
    issue(3'd0, 13'h0500, 1'b0, "R1 read under global");

    // R9 sticky and W1C
    cfg_write(A_STS, 32'h0);
    chk(blk_sts === 1'b1, "R9 write 0 keeps status", {31'd0, blk_sts}, 32'h1);
    cfg_write(A_STS, 32'h1);
    chk(blk_sts === 1'b0, "R9 write 1 clears", {31'd0, blk_sts}, 32'h0);

    // R5 relax needs override
    cfg_write(A_CTRL, 32'h0);
    chk(gwp_active === 1'b1, "R5 clear without override", {31'd0, gwp_active}, 32'h1);
    ovr_req = 1'b1;
    cfg_write(A_CTRL, 32'h0);
    ovr_req = 1'b0;
    chk(gwp_active === 1'b0, "R5 clear with override", {31'd0, gwp_active}, 32'h0);
    issue(3'd1, 13'h0500, 1'b0, "R4 write passes once relaxed");

    // Vector table: R1, R2, R3, R7, R8
    for (int i = 0; i < 9; i++) begin
      issue(VEC[i][16:14], VEC[i][13:1], VEC[i][0],
            $sformatf("R1/R2/R3/R7/R8 vector %0d", i));
    end

    // R9 set wins over same-cycle clear
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd1; req_addr = {13'h0010, 12'h0};
    cfg_we = 1'b1; cfg_addr = A_STS; cfg_wdata = 32'h1;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    chk(blk_sts === 1'b1 && cmd_done === 1'b1, "R9 set wins",
        {30'd0, blk_sts, cmd_done}, 32'h3);
    cfg_write(A_STS, 32'h1);

    // R10 request while outstanding is ignored
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd1; req_addr = {13'h0400, 12'h0};
    @(negedge clk);
    chk(fwd_valid === 1'b1, "R10 first forward", {31'd0, fwd_valid}, 32'h1);
    req_addr = {13'h0010, 12'h0};
    @(negedge clk);
    req_valid = 1'b0;
    chk(fwd_valid === 0 && cmd_done === 0 && blk_sts === 0,
        "R10 busy request ignored", {29'd0, fwd_valid, cmd_done, blk_sts}, 32'h0);
    flash_done = 1'b1;
    @(negedge clk);
    flash_done = 1'b0;
    chk(cmd_done === 1'b1, "R8 done after flash_done", {31'd0, cmd_done}, 32'h1);

    // R6 lock freezes configuration
    cfg_write(A_CTRL, 32'h1);
    chk(wp_locked === 1'b1, "R6 lock set", {31'd0, wp_locked}, 32'h1);
    cfg_write(3'd0, 32'h0);
    cfg_write(A_OPTAB, 32'h0);
    issue(3'd1, 13'h0010, 1'b1, "R6 range and table frozen");
    cfg_write(A_CTRL, 32'h2);
    chk(gwp_active === 1'b0, "R6 global flag frozen", {31'd0, gwp_active}, 32'h0);
    cfg_write(A_CTRL, 32'h0);
    chk(wp_locked === 1'b1, "R6 lock holds", {31'd0, wp_locked}, 32'h1);

    // R11 reset clears lock and restores protection
    do_reset();
    chk(wp_locked === 0 && gwp_active === 1 && blk_sts === 0,
        "R11 reset after lock", {29'd0, wp_locked, gwp_active, blk_sts}, 32'h2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule